// File: doc/BRIEF.md
# Reloading Down-Counter Pulse Generator

This block is a down-counting timer that produces square waves. A selectable count-source tick makes the counter decrement by one while the run control is high. When a tick arrives and the counter already holds zero, the counter takes the value of a reload register instead of wrapping. That event is an underflow. Each underflow flips the level of two pulse outputs, raises a sticky status flag and produces a one-cycle interrupt request. Each half period of the outputs therefore lasts reload+1 ticks.

Software sees the timer as a small set of control inputs: run, a starting-level select, a stop for the first output and a pad enable for it. It also has a write strobe with data for the count value and a clear strobe for the status flag. The count source is one bit of a vector of divided-clock tick enables, picked by a select field. A write made while the timer is stopped loads both the counter and the reload register. A write made while it runs changes only the reload value, and the counter picks that value up at its next underflow.

Top module: `rdc_pulse_gen`

## Requirements
- R1: After reset the counter and the reload register hold FFFFh, the status flag and interrupt request are 0, and the outputs sit at the starting level chosen by `init_low_i`.
- R2: While `run_i` is 1, each cycle in which the selected tick is 1 and the counter is non-zero lowers the counter by exactly one. The counter holds when `run_i` is 0 or the selected tick is 0, unless a write occurs.
- R3: A selected tick while running with the counter at zero loads the reload value into the counter and is an underflow. With a reload value N, consecutive underflows are N+1 ticks apart.
- R4: A write while `run_i` is 0 loads both the counter and the reload register. A write while running updates only the reload register, except in a cycle that also underflows, where the counter takes the written value.
- R5: `irq_o` is high for the single cycle after each underflow cycle, and is low otherwise.
- R6: `pulse_b_o` inverts on every underflow. It equals NOT `init_low_i` XOR the underflow parity since the last start, so with `init_low_i`=0 it starts high. A rising edge of `run_i` resets the parity to 0, and this takes priority over an underflow in the same cycle.
- R7: `unf_flag_o` is set by an underflow and stays set until a `flag_clr_i` pulse. When an underflow and a clear fall in the same cycle, the flag ends up set.
- R8: While `a_stop_i` is 1, `pulse_a_o` holds the starting level (NOT `init_low_i`). Otherwise it equals `pulse_b_o`. `pulse_b_o` is unaffected by `a_stop_i`.
- R9: `pulse_a_en_o` is 1 only when `a_oe_i` is 1. The pad of the first output is undriven otherwise.
- R10: The count source is `src_ticks_i[src_sel_i]`, where `src_sel_i` is a 3-bit index. Ticks on unselected bits have no effect on the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_ticks_i | input | 8 | Tick enables of the divided clocks |
| src_sel_i | input | 3 | Index of the tick enable used as count source |
| run_i | input | 1 | Start (1) / stop (0) control |
| init_low_i | input | 1 | Starting level select: 0 starts high, 1 starts low |
| a_stop_i | input | 1 | Holds the first output at its starting level |
| a_oe_i | input | 1 | Pad output enable for the first output |
| wr_en_i | input | 1 | Write strobe for the count value |
| wr_data_i | input | 16 | Count value to write |
| flag_clr_i | input | 1 | Clears the underflow status flag |
| cnt_o | output | 16 | Current counter value |
| irq_o | output | 1 | One-cycle interrupt request |
| unf_flag_o | output | 1 | Sticky underflow status flag |
| pulse_a_o | output | 1 | First pulse output level |
| pulse_a_en_o | output | 1 | Pad drive enable of the first pulse output |
| pulse_b_o | output | 1 | Second pulse output level |

## Verification
The hardest cases to reach from the ports are the ones where two things coincide in one cycle. These are an underflow together with a flag clear, a running write landing on the underflow tick, and a start edge meeting a zero count. Each needs the counter at zero and a selected tick in exactly that cycle. The bench sets up those collisions on purpose: it loads a reload value of zero, ticks every cycle and holds the clear strobe high. It then runs a long seeded random phase with small reload values and frequent strobes, so that underflows come every few cycles and overlap often with writes, clears, run edges and source switches. A cycle model in the bench checks every output after every edge.

// File: rtl/rdc_pulse_gen_pkg.sv
package rdc_pulse_gen_pkg;

  // Value that the counter and reload register take out of reset.
  function automatic logic [63:0] all_ones(input int w);
    logic [63:0] v;
    v = '0;
    for (int i = 0; i < w; i++) v[i] = 1'b1;
    return v;
  endfunction

  // Underflow-side events produced by the counting core.
  typedef struct packed {
    logic unf;    // underflow in this cycle
    logic start;  // run rising edge in this cycle
  } core_evt_t;

endpackage

// File: rtl/rdc_rst_sync.sv
module rdc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[LAST-1:0], 1'b1};
  end

  assign rst_s_n = sync_q[LAST];
endmodule

// File: rtl/rdc_src_mux.sv
module rdc_src_mux #(
  parameter int SRC_N = 8,
  localparam int SEL_W = (SRC_N > 1) ? $clog2(SRC_N) : 1
) (
  input  logic [SRC_N-1:0] src_ticks_i,
  input  logic [SEL_W-1:0] src_sel_i,
  output logic             tick_o
);
  always_comb begin
    tick_o = 1'b0;
    for (int i = 0; i < SRC_N; i++) begin
      if (src_sel_i == SEL_W'(i)) tick_o = src_ticks_i[i];
    end
  end
endmodule

// File: rtl/rdc_count_core.sv
module rdc_count_core
  import rdc_pulse_gen_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] rld_o,
  output logic             run_q_o,
  output core_evt_t        evt_o
);
  localparam logic [CNT_W-1:0] RST_VAL = CNT_W'(all_ones(CNT_W));
  localparam logic [CNT_W-1:0] ZERO    = '0;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] rld_q, rld_d;
  logic             run_q;
  logic             step;
  logic             unf;

  always_comb begin
    cnt_d = cnt_q;
    rld_d = rld_q;
    step  = run_i & tick_i;
    unf   = 1'b0;
    if (step) begin
      if (cnt_q == ZERO) begin
        unf   = 1'b1;
        cnt_d = rld_q;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
    if (wr_en_i) begin
      rld_d = wr_data_i;
      if (!run_i || unf) cnt_d = wr_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RST_VAL;
      rld_q <= RST_VAL;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rld_q <= rld_d;
      run_q <= run_i;
    end
  end

  assign cnt_o       = cnt_q;
  assign rld_o       = rld_q;
  assign run_q_o     = run_q;
  assign evt_o.unf   = unf;
  assign evt_o.start = run_i & ~run_q;
endmodule

// File: rtl/rdc_wave_out.sv
module rdc_wave_out
  import rdc_pulse_gen_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  core_evt_t evt_i,
  input  logic      init_low_i,
  input  logic      a_stop_i,
  input  logic      a_oe_i,
  output logic      pulse_a_o,
  output logic      pulse_a_en_o,
  output logic      pulse_b_o
);
  logic par_q, par_d;
  logic idle_lvl;
  logic level;

  always_comb begin
    par_d = par_q;
    if (evt_i.start)    par_d = 1'b0;
    else if (evt_i.unf) par_d = ~par_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) par_q <= 1'b0;
    else        par_q <= par_d;
  end

  assign idle_lvl     = ~init_low_i;
  assign level        = idle_lvl ^ par_q;
  assign pulse_b_o    = level;
  assign pulse_a_o    = a_stop_i ? idle_lvl : level;
  assign pulse_a_en_o = a_oe_i;
endmodule

// File: rtl/rdc_status.sv
module rdc_status (
  input  logic clk,
  input  logic rst_n,
  input  logic unf_i,
  input  logic clr_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q, flag_d;
  logic irq_q;

  always_comb begin
    flag_d = flag_q;
    if (unf_i)      flag_d = 1'b1;
    else if (clr_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= unf_i;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/rdc_pulse_gen.sv
module rdc_pulse_gen
  import rdc_pulse_gen_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SRC_N = 8,
  localparam int SEL_W = (SRC_N > 1) ? $clog2(SRC_N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] src_ticks_i,
  input  logic [SEL_W-1:0] src_sel_i,
  input  logic             run_i,
  input  logic             init_low_i,
  input  logic             a_stop_i,
  input  logic             a_oe_i,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o,
  output logic             unf_flag_o,
  output logic             pulse_a_o,
  output logic             pulse_a_en_o,
  output logic             pulse_b_o
);
  logic             rst_s_n;
  logic             tick_sel;
  logic [CNT_W-1:0] rld_q;
  logic             run_q;
  core_evt_t        evt;

  rdc_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  rdc_src_mux #(.SRC_N(SRC_N)) u_mux (
    .src_ticks_i (src_ticks_i),
    .src_sel_i   (src_sel_i),
    .tick_o      (tick_sel)
  );

  rdc_count_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .tick_i    (tick_sel),
    .run_i     (run_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .cnt_o     (cnt_o),
    .rld_o     (rld_q),
    .run_q_o   (run_q),
    .evt_o     (evt)
  );

  rdc_wave_out u_wave (
    .clk          (clk),
    .rst_n        (rst_s_n),
    .evt_i        (evt),
    .init_low_i   (init_low_i),
    .a_stop_i     (a_stop_i),
    .a_oe_i       (a_oe_i),
    .pulse_a_o    (pulse_a_o),
    .pulse_a_en_o (pulse_a_en_o),
    .pulse_b_o    (pulse_b_o)
  );

  rdc_status u_stat (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .unf_i  (evt.unf),
    .clr_i  (flag_clr_i),
    .flag_o (unf_flag_o),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/rdc_pulse_gen_chk.sv
module rdc_pulse_gen_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             run_i,
  input logic             run_q,
  input logic             wr_en_i,
  input logic             flag_clr_i,
  input logic             init_low_i,
  input logic             a_stop_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic [CNT_W-1:0] rld,
  input logic             irq_o,
  input logic             unf_flag_o,
  input logic             pulse_a_o,
  input logic             pulse_b_o
);
  a_r2_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && tick && cnt_o != '0 && !wr_en_i) |=> (cnt_o == $past(cnt_o) - CNT_W'(1)));

  a_r2_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !wr_en_i) |=> $stable(cnt_o));

  a_r3_reload_taken: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (cnt_o == rld));

  a_r5_irq_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> unf_flag_o);

  a_r6_b_inverts: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && $past(run_q) && $stable(init_low_i)) |-> (pulse_b_o != $past(pulse_b_o)));

  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (unf_flag_o && !flag_clr_i) |=> unf_flag_o);

  a_r8_a_follows_b: assert property (@(posedge clk) disable iff (!rst_n)
    !a_stop_i |-> (pulse_a_o == pulse_b_o));
endmodule

bind rdc_pulse_gen rdc_pulse_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_s_n),
  .tick       (tick_sel),
  .run_i      (run_i),
  .run_q      (run_q),
  .wr_en_i    (wr_en_i),
  .flag_clr_i (flag_clr_i),
  .init_low_i (init_low_i),
  .a_stop_i   (a_stop_i),
  .cnt_o      (cnt_o),
  .rld        (rld_q),
  .irq_o      (irq_o),
  .unf_flag_o (unf_flag_o),
  .pulse_a_o  (pulse_a_o),
  .pulse_b_o  (pulse_b_o)
);

// File: tb/rdc_pulse_gen_bench.sv
module rdc_pulse_gen_bench;
  localparam int CNT_W = 16;
  localparam int SRC_N = 8;

  logic             clk;
  logic             rst_n;
  logic [SRC_N-1:0] src_ticks;
  logic [2:0]       src_sel;
  logic             run, init_low, a_stop, a_oe, wr_en, flag_clr;
  logic [CNT_W-1:0] wr_data;
  logic [CNT_W-1:0] cnt;
  logic             irq, flag, pa, pa_en, pb;

  int n_checks = 0;
  int n_errors = 0;

  // reference state
  logic [CNT_W-1:0] m_cnt, m_rld;
  logic             m_runq, m_par, m_flag, m_irq;

  rdc_pulse_gen #(.CNT_W(CNT_W), .SRC_N(SRC_N)) u_rdc_pulse_gen (
    .clk (clk), .rst_n (rst_n),
    .src_ticks_i (src_ticks), .src_sel_i (src_sel),
    .run_i (run), .init_low_i (init_low), .a_stop_i (a_stop), .a_oe_i (a_oe),
    .wr_en_i (wr_en), .wr_data_i (wr_data), .flag_clr_i (flag_clr),
    .cnt_o (cnt), .irq_o (irq), .unf_flag_o (flag),
    .pulse_a_o (pa), .pulse_a_en_o (pa_en), .pulse_b_o (pb)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_b();
    return (~init_low) ^ m_par;
  endfunction

  // one clock: advance the reference, then compare every output
  task automatic cyc();
    logic step, unf, start;
    logic [CNT_W-1:0] n_cnt, n_rld;
    step  = run & src_ticks[src_sel];
    unf   = step && (m_cnt == '0);
    start = run && !m_runq;
    n_cnt = m_cnt;
    n_rld = m_rld;
    if (step) n_cnt = unf ? m_rld : m_cnt - 1'b1;
    if (wr_en) begin
      n_rld = wr_data;
      if (!run || unf) n_cnt = wr_data;
    end
    @(posedge clk);
    #2;
    m_cnt  = n_cnt;
    m_rld  = n_rld;
    m_runq = run;
    m_par  = start ? 1'b0 : (unf ? ~m_par : m_par);
    m_flag = unf ? 1'b1 : (flag_clr ? 1'b0 : m_flag);
    m_irq  = unf;
    chk(cnt == m_cnt, "R2 R3 R4 R10 counter", cnt, m_cnt);
    chk(irq == m_irq, "R5 irq", irq, m_irq);
    chk(flag == m_flag, "R7 flag", flag, m_flag);
    chk(pb == exp_b(), "R6 pulse_b", pb, exp_b());
    chk(pa == (a_stop ? ~init_low : exp_b()), "R8 pulse_a", pa, a_stop ? ~init_low : exp_b());
    chk(pa_en == a_oe, "R9 pad enable", pa_en, a_oe);
  endtask

  task automatic idle_inputs();
    src_ticks = '0; src_sel = 3'd0; run = 1'b0; init_low = 1'b0;
    a_stop = 1'b0; a_oe = 1'b1; wr_en = 1'b0; wr_data = '0; flag_clr = 1'b0;
  endtask

  initial begin : watchdog
    #(64'd20 * 64'd200000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin : main
    int gap;
    void'($urandom(32'h5eed1234));
    idle_inputs();
    rst_n = 1'b0;
    m_cnt = '1; m_rld = '1; m_runq = 1'b0; m_par = 1'b0; m_flag = 1'b0; m_irq = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    // R1 reset state
    chk(cnt == 16'hFFFF, "R1 reset counter", cnt, 16'hFFFF);
    chk(flag == 1'b0 && irq == 1'b0, "R1 reset flag/irq", {flag, irq}, 0);
    chk(pb == 1'b1, "R1 reset level high", pb, 1);

    // R4 stopped write loads counter
    wr_en = 1'b1; wr_data = 16'd4; cyc(); wr_en = 1'b0;
    chk(cnt == 16'd4, "R4 stopped write", cnt, 4);

    // R10 ticks on an unselected source are ignored
    src_sel = 3'd3; src_ticks = 8'h20; run = 1'b1;
    repeat (5) cyc();
    chk(cnt == 16'd4, "R10 unselected source", cnt, 4);

    // R3 period of reload+1 ticks
    src_ticks = 8'h08;
    gap = 0;
    while (!irq && gap < 20) begin cyc(); gap++; end
    chk(gap == 5, "R3 first underflow gap", gap, 5);
    gap = 0;
    do begin cyc(); gap++; end while (!irq && gap < 20);
    chk(gap == 5, "R3 reload period", gap, 5);

    // R4 running write goes to reload only
    src_ticks = 8'h00;
    wr_en = 1'b1; wr_data = 16'd0; cyc(); wr_en = 1'b0;
    chk(cnt == m_cnt && cnt != 16'd0, "R4 running write keeps counter", cnt, m_cnt);

    // R7 clear collides with underflow every cycle: flag stays set
    src_ticks = 8'h08; flag_clr = 1'b1;
    repeat (12) cyc();
    chk(flag == 1'b1, "R7 set wins over clear", flag, 1);
    src_ticks = 8'h00; cyc(); flag_clr = 1'b0;
    chk(flag == 1'b0, "R7 clear", flag, 0);

    // R8 stop first output, R6 second keeps going
    a_stop = 1'b1; src_ticks = 8'h08;
    repeat (6) cyc();
    chk(pa == 1'b1, "R8 stopped output at start level", pa, 1);
    a_stop = 1'b0; a_oe = 1'b0; cyc();
    chk(pa_en == 1'b0, "R9 pad disabled", pa_en, 0);

    // R6 restart resets parity
    run = 1'b0; cyc(); init_low = 1'b1; run = 1'b1; src_ticks = 8'h00; cyc();
    chk(pb == 1'b0, "R6 restart at low start level", pb, 0);

    // seeded random phase
    for (int i = 0; i < 6000; i++) begin
      src_ticks = 8'($urandom);
      if ($urandom_range(0, 99) < 3)  run = ~run;
      if ($urandom_range(0, 99) < 4)  src_sel = 3'($urandom);
      if ($urandom_range(0, 99) < 1)  init_low = ~init_low;
      if ($urandom_range(0, 99) < 5)  a_stop = ~a_stop;
      if ($urandom_range(0, 99) < 5)  a_oe = ~a_oe;
      wr_en    = ($urandom_range(0, 99) < 6);
      wr_data  = ($urandom_range(0, 9) == 0) ? 16'($urandom) : 16'($urandom_range(0, 6));
      flag_clr = ($urandom_range(0, 99) < 12);
      cyc();
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule